// File: doc/BRIEF.md
# DMA Request Line Allocator

This block shares a small set of external DMA request lines among USB endpoints. It holds a packed endpoint map with one 5-bit field per request slot, and a per-endpoint interrupt mask. A client asks for a line by giving an endpoint number and a direction. One cycle later the block answers with a granted slot index or a busy refusal. A release returns a line to the pool, sets the endpoint's mask bit again and pulses the matching bit of an interrupt-clear vector.

A mode input selects between two behaviours. In multichannel operation each endpoint owns a slot of its own, found by a first-free search. In shared operation a single line, slot 0, is lent to one endpoint at a time. Release is owner-checked in that mode. A read port returns either the map or the mask.

Top module: `dma_line_alloc`

## Requirements
- R1: After reset the map reads 0, the mask reads 0x7FFFFFFF, and grant_valid, alloc_busy, rel_err and int_clr are all low.
- R2: The map read (rd_sel=0) places slot i at bits [5i+4:5i]. Within a field, bits [3:0] hold the endpoint and bit 4 is 1 for transmit. Bits 31:30 read 0. rd_sel=1 reads the mask.
- R3: In multichannel mode (shared_mode=0) a request takes the lowest slot among 0..4 whose endpoint nibble is zero. If none is zero the request gets busy. Slot 5 is never granted.
- R4: In multichannel mode a release clears all five bits of the field named by rel_slot. A rel_slot of 5 or more is ignored and pulses rel_err.
- R5: In shared mode (shared_mode=1) a request is refused as busy while the whole map is nonzero. Otherwise it is granted slot 0, and field 0 is written with {tx, endpoint}.
- R6: In shared mode a release whose endpoint differs from map bits [3:0] changes nothing and pulses rel_err. A matching release clears the whole map.
- R7: A request for endpoint 0 is always refused as busy.
- R8: The mask bit of transmit endpoint n is bit n, and that of receive endpoint n is bit n+15. A grant clears that bit.
- R9: An accepted release sets its endpoint's mask bit. It also drives int_clr high on exactly that bit for one cycle. Otherwise int_clr is zero.
- R10: When a release and a request arrive in the same cycle, the release is applied first, and the request sees the map and mask as the release left them.
- R11: grant_valid or alloc_busy is high for one cycle, exactly one cycle after each request, and never both. grant_slot carries the slot while grant_valid is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shared_mode | input | 1 | 1 selects single shared-line operation |
| alloc_req | input | 1 | Allocate strobe, one cycle |
| alloc_ep | input | 4 | Endpoint to allocate for |
| alloc_tx | input | 1 | Direction of allocation, 1 = transmit |
| rel_req | input | 1 | Release strobe, one cycle |
| rel_ep | input | 4 | Endpoint being released |
| rel_tx | input | 1 | Direction of release, 1 = transmit |
| rel_slot | input | 3 | Slot to clear in multichannel mode |
| rd_sel | input | 1 | 0 reads the map, 1 reads the mask |
| grant_valid | output | 1 | Request granted, one-cycle strobe |
| grant_slot | output | 3 | Granted slot index |
| alloc_busy | output | 1 | Request refused, one-cycle strobe |
| rel_err | output | 1 | Release rejected, one-cycle strobe |
| int_clr | output | 32 | One-cycle interrupt-clear pulse |
| rd_data | output | 32 | Map or mask read data |

## Verification
The bench fills all five slots and then asks again. A search that reaches the sixth field would hand out slot 5 instead of refusing. It frees a middle slot and checks that the next request reuses that slot and not a higher one. It also releases slot 5, which must be rejected and must not wipe the reserved field. Same-cycle release and request pairs show whether the release is really applied first. A design that gets the order wrong refuses a request that ought to succeed, or leaves a mask bit set. In shared mode the bench releases from a non-owner, which must leave the map intact. It also requests endpoint 0, which must be refused even when slots are free.

// File: rtl/dla_pkg.sv
package dla_pkg;
  localparam int EP_BITS    = 4;
  localparam int SLOTS_ALL  = 6;
  localparam int SLOTS_USE  = 5;
  localparam int RX_OFFSET  = 15;

  // Interrupt/mask bit position of an endpoint and direction.
  function automatic int irq_bit(input int ep, input logic tx, input int rx_base);
    return tx ? ep : ep + rx_base;
  endfunction

  // Start bit of a slot's field in the packed map.
  function automatic int field_lsb(input int slot, input int field_w);
    return slot * field_w;
  endfunction
endpackage

// File: rtl/dla_slot_search.sv
module dla_slot_search #(
  parameter int FIELD_W = 5,
  parameter int NUM_FIELDS = 6,
  parameter int USABLE = 5,
  parameter int SLOT_W = 3
) (
  input  logic [FIELD_W*NUM_FIELDS-1:0] map_in,
  output logic                          found,
  output logic [SLOT_W-1:0]             idx
);
  localparam int EPW = FIELD_W - 1;

  // Walk downward so the lowest free slot is the one left standing.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = USABLE - 1; i >= 0; i--) begin
      if (map_in[dla_pkg::field_lsb(i, FIELD_W) +: EPW] == '0) begin
        found = 1'b1;
        idx   = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/dla_mask_reg.sv
module dla_mask_reg #(
  parameter int REG_W = 32,
  parameter int EP_W = 4,
  parameter int RX_BASE = 15,
  parameter logic [REG_W-1:0] INIT = 32'h7FFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [EP_W-1:0]  set_ep,
  input  logic             set_tx,
  input  logic             clr_en,
  input  logic [EP_W-1:0]  clr_ep,
  input  logic             clr_tx,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] int_clr_q
);
  localparam int IDX_W = $clog2(REG_W);

  logic [IDX_W-1:0] set_idx, clr_idx;
  logic [REG_W-1:0] mask_n, pulse_n;

  assign set_idx = IDX_W'(dla_pkg::irq_bit(int'(set_ep), set_tx, RX_BASE));
  assign clr_idx = IDX_W'(dla_pkg::irq_bit(int'(clr_ep), clr_tx, RX_BASE));

  // Release (set) applies before allocation (clear).
  always_comb begin
    mask_n  = mask_q;
    pulse_n = '0;
    if (set_en) begin
      mask_n[set_idx]  = 1'b1;
      pulse_n[set_idx] = 1'b1;
    end
    if (clr_en) mask_n[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= INIT;
      int_clr_q <= '0;
    end else begin
      mask_q    <= mask_n;
      int_clr_q <= pulse_n;
    end
  end
endmodule

// File: rtl/dma_line_alloc.sv
module dma_line_alloc #(
  parameter int EP_W = dla_pkg::EP_BITS,
  parameter int NUM_FIELDS = dla_pkg::SLOTS_ALL,
  parameter int USABLE = dla_pkg::SLOTS_USE,
  parameter int SLOT_W = 3,
  parameter int REG_W = 32,
  parameter int RX_BASE = dla_pkg::RX_OFFSET,
  parameter logic [31:0] MASK_INIT = 32'h7FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shared_mode,
  input  logic              alloc_req,
  input  logic [EP_W-1:0]   alloc_ep,
  input  logic              alloc_tx,
  input  logic              rel_req,
  input  logic [EP_W-1:0]   rel_ep,
  input  logic              rel_tx,
  input  logic [SLOT_W-1:0] rel_slot,
  input  logic              rd_sel,
  output logic              grant_valid,
  output logic [SLOT_W-1:0] grant_slot,
  output logic              alloc_busy,
  output logic              rel_err,
  output logic [REG_W-1:0]  int_clr,
  output logic [REG_W-1:0]  rd_data
);
  localparam int FIELD_W = EP_W + 1;
  localparam int MAP_W   = FIELD_W * NUM_FIELDS;

  logic [MAP_W-1:0]  map_q, map_rel, map_n;
  logic [REG_W-1:0]  mask_q;
  logic              rel_in_range, owner_ok, rel_accept;
  logic              free_found, alloc_grant, alloc_refuse;
  logic [SLOT_W-1:0] free_idx, grant_idx;

  // Release stage
  assign rel_in_range = rel_slot < SLOT_W'(USABLE);
  assign owner_ok     = map_q[EP_W-1:0] == rel_ep;
  assign rel_accept   = rel_req && (shared_mode ? owner_ok : rel_in_range);

  always_comb begin
    map_rel = map_q;
    if (rel_accept && shared_mode) map_rel = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rel_accept && !shared_mode && SLOT_W'(i) == rel_slot)
        map_rel[dla_pkg::field_lsb(i, FIELD_W) +: FIELD_W] = '0;
    end
  end

  // Allocation stage, on the post-release map
  dla_slot_search #(
    .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .USABLE(USABLE), .SLOT_W(SLOT_W)
  ) u_search (
    .map_in(map_rel), .found(free_found), .idx(free_idx)
  );

  assign alloc_grant  = alloc_req && (alloc_ep != '0) &&
                        (shared_mode ? (map_rel == '0) : free_found);
  assign alloc_refuse = alloc_req && !alloc_grant;
  assign grant_idx    = shared_mode ? '0 : free_idx;

  always_comb begin
    map_n = map_rel;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (alloc_grant && SLOT_W'(i) == grant_idx)
        map_n[dla_pkg::field_lsb(i, FIELD_W) +: FIELD_W] = {alloc_tx, alloc_ep};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q       <= '0;
      grant_valid <= 1'b0;
      grant_slot  <= '0;
      alloc_busy  <= 1'b0;
      rel_err     <= 1'b0;
    end else begin
      map_q       <= map_n;
      grant_valid <= alloc_grant;
      grant_slot  <= alloc_grant ? grant_idx : '0;
      alloc_busy  <= alloc_refuse;
      rel_err     <= rel_req && !rel_accept;
    end
  end

  dla_mask_reg #(
    .REG_W(REG_W), .EP_W(EP_W), .RX_BASE(RX_BASE), .INIT(REG_W'(MASK_INIT))
  ) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_en(rel_accept), .set_ep(rel_ep), .set_tx(rel_tx),
    .clr_en(alloc_grant), .clr_ep(alloc_ep), .clr_tx(alloc_tx),
    .mask_q(mask_q), .int_clr_q(int_clr)
  );

  assign rd_data = rd_sel ? mask_q : {{(REG_W-MAP_W){1'b0}}, map_q};
endmodule

// File: rtl/dla_checker.sv
module dla_checker #(
  parameter int EP_W = 4,
  parameter int USABLE = 5,
  parameter int SLOT_W = 3,
  parameter int REG_W = 32,
  parameter int RX_BASE = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shared_mode,
  input logic              alloc_req,
  input logic [EP_W-1:0]   alloc_ep,
  input logic              alloc_tx,
  input logic              rel_req,
  input logic              grant_valid,
  input logic [SLOT_W-1:0] grant_slot,
  input logic              alloc_busy,
  input logic              rel_err,
  input logic [REG_W-1:0]  int_clr,
  input logic [REG_W-1:0]  mask_q,
  input logic              rel_accept,
  input logic              alloc_grant
);
  localparam int IDX_W = $clog2(REG_W);
  logic [IDX_W-1:0] alloc_bit;
  assign alloc_bit = IDX_W'(dla_pkg::irq_bit(int'(alloc_ep), alloc_tx, RX_BASE));

  AST_EP0_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && alloc_ep == '0 |=> alloc_busy && !grant_valid); // R7
  AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant_slot < SLOT_W'(USABLE)); // R3
  AST_SHARED_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && shared_mode |=> alloc_busy || grant_slot == '0); // R5
  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && alloc_busy)); // R11
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |=> !grant_valid && !alloc_busy); // R11
  AST_GRANT_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> !mask_q[$past(alloc_bit)]); // R8
  AST_CLR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rel_accept |=> $countones(int_clr) == 1); // R9
  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_accept |=> int_clr == '0); // R9
  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rel_req && !rel_accept |=> rel_err && $onehot0(int_clr) && int_clr == '0); // R6
endmodule

bind dma_line_alloc dla_checker #(
  .EP_W(EP_W), .USABLE(USABLE), .SLOT_W(SLOT_W), .REG_W(REG_W), .RX_BASE(RX_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .shared_mode(shared_mode),
  .alloc_req(alloc_req), .alloc_ep(alloc_ep), .alloc_tx(alloc_tx),
  .rel_req(rel_req), .grant_valid(grant_valid), .grant_slot(grant_slot),
  .alloc_busy(alloc_busy), .rel_err(rel_err), .int_clr(int_clr),
  .mask_q(mask_q), .rel_accept(rel_accept), .alloc_grant(alloc_grant)
);

// File: tb/dma_line_alloc_test.sv
`timescale 1ns/1ps
module dma_line_alloc_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic shared_mode = 0, alloc_req = 0, alloc_tx = 0, rel_req = 0, rel_tx = 0, rd_sel = 0;
  logic [3:0] alloc_ep = 0, rel_ep = 0;
  logic [2:0] rel_slot = 0;
  logic grant_valid, alloc_busy, rel_err;
  logic [2:0] grant_slot;
  logic [31:0] int_clr, rd_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [29:0] ref_map;
  logic [31:0] ref_mask;
  logic e_gv, e_busy, e_err;
  logic [2:0] e_slot;
  logic [31:0] e_clr;

  always #4 clk = ~clk;

  dma_line_alloc uut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int mbit(input logic [3:0] ep, input logic tx);
    int b = ep;
    if (!tx) b = b + 15;
    return b;
  endfunction

  // Reference model: release first, then request.
  task automatic model(input logic md, input logic arq, input logic [3:0] aep, input logic atx,
                       input logic rrq, input logic [3:0] rep, input logic rtx, input logic [2:0] rsl);
    logic [29:0] m = ref_map;
    logic ok;
    e_gv = 0; e_busy = 0; e_err = 0; e_slot = 0; e_clr = 0;
    if (rrq) begin
      ok = md ? (m[3:0] == rep) : (rsl <= 3'd4);
      if (ok) begin
        if (md) m = '0;
        else for (int s = 0; s < 5; s++) if (s == rsl) m[s*5 +: 5] = 5'd0;
        ref_mask[mbit(rep, rtx)] = 1'b1;
        e_clr[mbit(rep, rtx)] = 1'b1;
      end else e_err = 1;
    end
    if (arq) begin
      e_busy = 1;
      if (aep != 0) begin
        if (md) begin
          if (m == 0) begin e_busy = 0; e_gv = 1; e_slot = 0; m[4:0] = {atx, aep}; end
        end else begin
          for (int s = 0; s < 5; s++)
            if (e_busy && m[s*5 +: 4] == 4'd0) begin
              e_busy = 0; e_gv = 1; e_slot = 3'(s); m[s*5 +: 5] = {atx, aep};
            end
        end
      end
      if (e_gv) ref_mask[mbit(aep, atx)] = 1'b0;
    end
    ref_map = m;
  endtask

  task automatic step(input string tag, input logic md, input logic arq, input logic [3:0] aep,
                      input logic atx, input logic rrq, input logic [3:0] rep, input logic rtx,
                      input logic [2:0] rsl);
    shared_mode = md; alloc_req = arq; alloc_ep = aep; alloc_tx = atx;
    rel_req = rrq; rel_ep = rep; rel_tx = rtx; rel_slot = rsl;
    model(md, arq, aep, atx, rrq, rep, rtx, rsl);
    @(posedge clk); @(negedge clk);
    alloc_req = 0; rel_req = 0;
    chk(tag, "grant_valid", 32'(grant_valid), 32'(e_gv));
    chk(tag, "alloc_busy", 32'(alloc_busy), 32'(e_busy));
    chk(tag, "grant_slot", 32'(grant_slot), 32'(e_slot));
    chk(tag, "rel_err", 32'(rel_err), 32'(e_err));
    chk("R9", "int_clr", int_clr, e_clr);
    rd_sel = 0; #1;
    chk("R2", "map", rd_data, {2'b00, ref_map});
    rd_sel = 1; #1;
    chk("R8", "mask", rd_data, ref_mask);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd2024);
    logic md = 0;
    ref_map = '0; ref_mask = 32'h7FFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "grant_valid", 32'(grant_valid), 0);
    chk("R1", "alloc_busy", 32'(alloc_busy), 0);
    chk("R1", "rel_err", 32'(rel_err), 0);
    chk("R1", "int_clr", int_clr, 0);
    rd_sel = 0; #1; chk("R1", "map", rd_data, 0);
    rd_sel = 1; #1; chk("R1", "mask", rd_data, 32'h7FFF_FFFF);

    // R3: fill the five usable slots, then one more is busy
    for (int e = 1; e <= 5; e++) step("R3", 0, 1, 4'(e), e[0], 0, 0, 0, 0);
    step("R3", 0, 1, 4'd6, 1, 0, 0, 0, 0);
    // R4: free a middle slot and reuse it; out-of-range slot is rejected
    step("R4", 0, 0, 0, 0, 1, 4'd3, 1, 3'd2);
    step("R3", 0, 1, 4'd7, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 1, 4'd7, 0, 3'd5);
    step("R4", 0, 0, 0, 0, 1, 4'd7, 0, 3'd7);
    // R7: endpoint 0 refused even with a free slot
    step("R4", 0, 0, 0, 0, 1, 4'd4, 0, 3'd3);
    step("R7", 0, 1, 4'd0, 1, 0, 0, 0, 0);
    // R10: release and request together; the freed slot is reused and mask ends cleared
    step("R10", 0, 1, 4'd1, 1, 1, 4'd1, 1, 3'd0);
    for (int s = 0; s < 5; s++) step("R4", 0, 0, 0, 0, 1, 4'(s + 1), 1, 3'(s));
    // R5/R6: shared line
    step("R5", 1, 1, 4'd9, 0, 0, 0, 0, 0);
    step("R5", 1, 1, 4'd10, 1, 0, 0, 0, 0);
    step("R6", 1, 0, 0, 0, 1, 4'd4, 0, 0);
    step("R10", 1, 1, 4'd11, 1, 1, 4'd9, 0, 0);
    step("R6", 1, 0, 0, 0, 1, 4'd11, 1, 0);
    step("R7", 1, 1, 4'd0, 0, 0, 0, 0, 0);

    // R11: constrained random mix
    for (int n = 0; n < 800; n++) begin
      if ($urandom_range(0, 59) == 0) md = ~md;
      step("R11", md, ($urandom_range(0, 2) != 0), 4'($urandom_range(0, 15)),
           1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
           4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
           3'($urandom_range(0, 7)));
    end
    if (seed == 32'hFFFF_FFFF) $display("seed wrap");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule